// File: doc/BRIEF.md
# Register Rename Map Unit

This unit sits between decode and issue in an out-of-order core. Every architected register write receives a fresh physical register. That register is written exactly once and may be read any number of times, so write-after-write and write-after-read conflicts between instructions disappear. Integer and floating-point names are handled in two fully separate spaces. Each space has its own map table and its own pool of unused physical registers.

Each cycle the unit takes one instruction with two source names and an optional destination name. The source tags come out combinationally from the current map, and so does the tag chosen for the destination. On the clock edge the destination's map entry is rewritten to that new tag. A later loop iteration therefore reads the value its predecessor produced. A loop-invariant operand that is never rewritten keeps the same physical register across iterations.

The commit side hands back physical registers that are no longer needed through a release port. Those registers are then queued for reuse. When the pool of the needed class is empty, the unit raises stall and changes nothing.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architected register i of either class maps to physical register i. The free pool of each class holds physical registers ARCH_REGS to PHYS_REGS-1.
- R2: A renaming instruction (req_valid=1, dst_valid=1, not integer register 0) that does not stall receives on dst_ptag the oldest tag in its class's pool, in the same cycle. The pool hands tags out first-in first-out: after reset they come in ascending order, then released tags follow in the order they were released.
- R3: From the cycle after a rename, source lookups of that architected register return the new tag. Registers that were not renamed keep their previous tag.
- R4: Sources are looked up before the destination update. An instruction that reads and writes the same register sees the old tag on its source output.
- R5: Class bit 0 selects the integer space and 1 selects the floating-point space. A rename in one class changes neither the map nor the pool of the other class.
- R6: Integer register 0 always reads as physical tag 0. An integer destination of 0 allocates nothing, drives dst_ptag=0, and never stalls.
- R7: stall is 1 exactly when a renaming instruction finds its class's pool empty. A stalled instruction changes no map entry and takes no tag, and dst_ptag is 0. The other class can still rename.
- R8: rel_valid=1 appends rel_ptag to the tail of the pool selected by rel_fp. A release and an allocation in the same class in the same cycle both take effect. A release into an empty pool does not clear a stall in that same cycle.
- R9: With req_valid=0 or dst_valid=0, no tag is allocated, dst_ptag is 0, and the map is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction present this cycle |
| src1_fp | input | 1 | Class of source 1 (1 = floating point) |
| src1_arch | input | $clog2(ARCH_REGS) | Architected name of source 1 |
| src2_fp | input | 1 | Class of source 2 |
| src2_arch | input | $clog2(ARCH_REGS) | Architected name of source 2 |
| dst_valid | input | 1 | Instruction writes a destination |
| dst_fp | input | 1 | Class of the destination |
| dst_arch | input | $clog2(ARCH_REGS) | Architected destination name |
| rel_valid | input | 1 | Commit side returns a physical register |
| rel_fp | input | 1 | Class of the returned register |
| rel_ptag | input | $clog2(PHYS_REGS) | Returned physical tag |
| src1_ptag | output | $clog2(PHYS_REGS) | Physical tag of source 1 |
| src2_ptag | output | $clog2(PHYS_REGS) | Physical tag of source 2 |
| dst_ptag | output | $clog2(PHYS_REGS) | Newly allocated destination tag, 0 when none |
| stall | output | 1 | Destination pool empty, instruction not accepted |

## Verification
A corrupted map entry shows up on the next source lookup of that register, which can be the very next cycle, as a tag that differs from the last one handed out for it. A wrong pool pointer or count shows up as an out-of-order or repeated dst_ptag, or as a stall at the wrong moment. That appears at the next allocation in the affected class. The bench sweeps every architected register of both classes after reset and after renames, drains each pool to empty, and recycles released tags through the pool. This way a bad entry or a lost tag reaches the ports within a few cycles.

// File: rtl/rn_pkg.sv
// Shared definitions for the register rename unit.
// Assumes: one class bit per operand, 0 = integer space, 1 = floating-point space.
package rn_pkg;
    typedef enum logic {
        RN_INT = 1'b0,
        RN_FP  = 1'b1
    } rn_cls_e;
endpackage

// File: rtl/rn_map_table.sv
// Map table for one register class: architected name -> physical tag.
// Two combinational read ports, one write port applied at the clock edge,
// so reads in a cycle always see the mapping from before that cycle's write.
// Assumes: PHYS_REGS >= ARCH_REGS. With ZERO_HARD set, entry 0 is pinned to tag 0.
module rn_map_table #(
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    parameter bit ZERO_HARD = 1'b0,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd1_addr,
    input  logic [AW-1:0] rd2_addr,
    output logic [PW-1:0] rd1_tag,
    output logic [PW-1:0] rd2_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_tag
);
    logic [PW-1:0] entry [ARCH_REGS];
    logic          wr_ok;

    // Writes to a pinned zero entry are dropped.
    assign wr_ok = wr_en && !(ZERO_HARD && (wr_addr == '0));

    // Identity mapping on reset, then one entry update per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                entry[i] <= PW'(i);
            end
        end else if (wr_ok) begin
            entry[wr_addr] <= wr_tag;
        end
    end

    // Source lookups from the pre-update state.
    always_comb begin
        rd1_tag = (ZERO_HARD && (rd1_addr == '0)) ? '0 : entry[rd1_addr];
        rd2_tag = (ZERO_HARD && (rd2_addr == '0)) ? '0 : entry[rd2_addr];
    end
endmodule

// File: rtl/rn_free_list.sv
// Circular first-in first-out pool of unused physical tags for one class.
// The head tag is visible combinationally. A pop and a push can happen in the
// same cycle. Reset fills the pool with tags ARCH_REGS .. PHYS_REGS-1 in order.
// Assumes: pop only when not empty, and no push when full without a pop
// (the commit side never returns more tags than were taken).
module rn_free_list #(
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    localparam int PW    = $clog2(PHYS_REGS),
    localparam int DEPTH = PHYS_REGS - ARCH_REGS,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_tag,
    output logic [PW-1:0] head_tag,
    output logic          empty
);
    logic [PW-1:0] slot [DEPTH];
    logic [IW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          push_ok;

    // A push is accepted unless the pool is full and nothing leaves it.
    assign push_ok  = push && ((count != CW'(DEPTH)) || pop);
    assign head_tag = slot[rd_ptr];
    assign empty    = (count == '0);

    // Wrap-around increment for a pool index.
    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Slot storage: reset contents, then the tail is written on a push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot[i] <= PW'(ARCH_REGS + i);
            end
        end else if (push_ok) begin
            slot[wr_ptr] <= push_tag;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(DEPTH);
        end else begin
            if (pop)     rd_ptr <= nxt(rd_ptr);
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rn_rename_unit.sv
// Register rename unit: one instruction per cycle, two sources, one optional
// destination. Integer and floating-point names are renamed in separate spaces,
// each with its own map table and free pool. Integer register 0 is pinned to
// physical tag 0 and never renamed.
// Assumes: the commit side releases only tags that were displaced by a rename.
module rn_rename_unit
    import rn_pkg::*;
#(
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          src1_fp,
    input  logic [AW-1:0] src1_arch,
    input  logic          src2_fp,
    input  logic [AW-1:0] src2_arch,
    input  logic          dst_valid,
    input  logic          dst_fp,
    input  logic [AW-1:0] dst_arch,
    input  logic          rel_valid,
    input  logic          rel_fp,
    input  logic [PW-1:0] rel_ptag,
    output logic [PW-1:0] src1_ptag,
    output logic [PW-1:0] src2_ptag,
    output logic [PW-1:0] dst_ptag,
    output logic          stall
);
    localparam int NCLS = 2;

    logic [PW-1:0] rd1_tag  [NCLS];
    logic [PW-1:0] rd2_tag  [NCLS];
    logic [PW-1:0] head_tag [NCLS];
    logic          empty    [NCLS];
    logic          need_alloc, do_alloc;

    // A destination needs a tag unless it is absent or integer register 0.
    assign need_alloc = req_valid && dst_valid &&
                        !((rn_cls_e'(dst_fp) == RN_INT) && (dst_arch == '0));
    // Stall when the destination's pool has nothing to give.
    assign stall      = need_alloc && empty[dst_fp];
    assign do_alloc   = need_alloc && !stall;

    // One map table and one pool per register class.
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam rn_cls_e CLS = rn_cls_e'(c);
        logic cls_alloc, cls_rel;

        assign cls_alloc = do_alloc  && (rn_cls_e'(dst_fp) == CLS);
        assign cls_rel   = rel_valid && (rn_cls_e'(rel_fp) == CLS);

        rn_map_table #(
            .ARCH_REGS(ARCH_REGS),
            .PHYS_REGS(PHYS_REGS),
            .ZERO_HARD(CLS == RN_INT)
        ) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd1_addr(src1_arch),
            .rd2_addr(src2_arch),
            .rd1_tag (rd1_tag[c]),
            .rd2_tag (rd2_tag[c]),
            .wr_en   (cls_alloc),
            .wr_addr (dst_arch),
            .wr_tag  (head_tag[c])
        );

        rn_free_list #(
            .ARCH_REGS(ARCH_REGS),
            .PHYS_REGS(PHYS_REGS)
        ) u_pool (
            .clk     (clk),
            .rst_n   (rst_n),
            .pop     (cls_alloc),
            .push    (cls_rel),
            .push_tag(rel_ptag),
            .head_tag(head_tag[c]),
            .empty   (empty[c])
        );
    end

    // Output selection by operand class.
    always_comb begin
        src1_ptag = rd1_tag[src1_fp];
        src2_ptag = rd2_tag[src2_fp];
        dst_ptag  = do_alloc ? head_tag[dst_fp] : '0;
    end
endmodule

// File: rtl/rn_rename_chk.sv
// Property checker for rn_rename_unit, attached with bind. It watches only
// the ports and keeps a one-cycle record of the last rename.
module rn_rename_chk #(
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          src1_fp,
    input logic [AW-1:0] src1_arch,
    input logic          src2_fp,
    input logic [AW-1:0] src2_arch,
    input logic          dst_valid,
    input logic          dst_fp,
    input logic [AW-1:0] dst_arch,
    input logic          rel_valid,
    input logic          rel_fp,
    input logic [PW-1:0] rel_ptag,
    input logic [PW-1:0] src1_ptag,
    input logic [PW-1:0] src2_ptag,
    input logic [PW-1:0] dst_ptag,
    input logic          stall
);
    logic          renamed;
    logic          last_ok;
    logic          last_fp;
    logic [AW-1:0] last_arch;
    logic [PW-1:0] last_tag;

    assign renamed = req_valid && dst_valid && (dst_fp || (dst_arch != '0)) && !stall;

    // Record of the previous cycle's rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ok   <= 1'b0;
            last_fp   <= 1'b0;
            last_arch <= '0;
            last_tag  <= '0;
        end else begin
            last_ok   <= renamed;
            last_fp   <= dst_fp;
            last_arch <= dst_arch;
            last_tag  <= dst_ptag;
        end
    end

    // R3
    new_map_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_ok && (src1_fp == last_fp) && (src1_arch == last_arch)) |-> (src1_ptag == last_tag));

    // R6
    int_zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src2_fp && (src2_arch == '0)) |-> (src2_ptag == '0));

    // R6
    int_zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dst_valid && !dst_fp && (dst_arch == '0)) |-> (!stall && (dst_ptag == '0)));

    // R7
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (req_valid && dst_valid && (dst_ptag == '0)));

    // R9
    idle_no_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && dst_valid) |-> (!stall && (dst_ptag == '0)));

    // R2
    int_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (renamed && !dst_fp) |-> (dst_ptag != '0));
endmodule

bind rn_rename_unit rn_rename_chk #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS)
) u_rn_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .src1_fp  (src1_fp),
    .src1_arch(src1_arch),
    .src2_fp  (src2_fp),
    .src2_arch(src2_arch),
    .dst_valid(dst_valid),
    .dst_fp   (dst_fp),
    .dst_arch (dst_arch),
    .rel_valid(rel_valid),
    .rel_fp   (rel_fp),
    .rel_ptag (rel_ptag),
    .src1_ptag(src1_ptag),
    .src2_ptag(src2_ptag),
    .dst_ptag (dst_ptag),
    .stall    (stall)
);

// File: tb/tb_rn_rename_unit.sv
// Self-checking bench on a small configuration (8 architected, 12 physical
// registers per class). Expected tags come from an arithmetic model of the
// requirements: a map per class plus first-in first-out pools.
module tb_rn_rename_unit;
    localparam int ARCH = 8;
    localparam int PHYS = 12;
    localparam int AW   = $clog2(ARCH);
    localparam int PW   = $clog2(PHYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, src1_fp = 1'b0, src2_fp = 1'b0;
    logic [AW-1:0] src1_arch = '0, src2_arch = '0, dst_arch = '0;
    logic          dst_valid = 1'b0, dst_fp = 1'b0;
    logic          rel_valid = 1'b0, rel_fp = 1'b0;
    logic [PW-1:0] rel_ptag = '0;
    logic [PW-1:0] src1_ptag, src2_ptag, dst_ptag;
    logic          stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int map_m [2][ARCH];
    int freeq [2][$];
    int pend  [2][$];

    rn_rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .src1_fp(src1_fp), .src1_arch(src1_arch),
        .src2_fp(src2_fp), .src2_arch(src2_arch),
        .dst_valid(dst_valid), .dst_fp(dst_fp), .dst_arch(dst_arch),
        .rel_valid(rel_valid), .rel_fp(rel_fp), .rel_ptag(rel_ptag),
        .src1_ptag(src1_ptag), .src2_ptag(src2_ptag),
        .dst_ptag(dst_ptag), .stall(stall)
    );

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < ARCH; i++) map_m[c][i] = (c == 0 && i == 0) ? 0 : i;
            freeq[c].delete();
            pend[c].delete();
            for (int t = ARCH; t < PHYS; t++) freeq[c].push_back(t);
        end
    endtask

    // One cycle: drive at the falling edge, check before the rising edge,
    // then update the model with what the rising edge commits.
    task automatic step(input string req, input bit rv,
                        input bit f1, input int a1, input bit f2, input int a2,
                        input bit dv, input bit df, input int da,
                        input bit rl, input bit rf);
        int  e1, e2, ed, tag;
        bit  need, est, alloc, do_rel;
        do_rel = rl && (pend[rf].size() > 0);
        tag    = do_rel ? pend[rf].pop_front() : 0;
        req_valid = rv; src1_fp = f1; src1_arch = AW'(a1);
        src2_fp = f2; src2_arch = AW'(a2);
        dst_valid = dv; dst_fp = df; dst_arch = AW'(da);
        rel_valid = do_rel; rel_fp = rf; rel_ptag = PW'(tag);
        #1;
        e1    = map_m[f1][a1];
        e2    = map_m[f2][a2];
        need  = rv && dv && !(!df && da == 0);
        est   = need && (freeq[df].size() == 0);
        alloc = need && !est;
        ed    = alloc ? freeq[df][0] : 0;
        chk(req, "src1_ptag", int'(src1_ptag), e1);
        chk(req, "src2_ptag", int'(src2_ptag), e2);
        chk(req, "dst_ptag",  int'(dst_ptag),  ed);
        chk(req, "stall",     int'(stall),     int'(est));
        @(posedge clk);
        if (alloc) begin
            pend[df].push_back(map_m[df][da]);
            map_m[df][da] = freeq[df].pop_front();
        end
        if (do_rel) freeq[rf].push_back(tag);
        @(negedge clk);
    endtask

    // Read every architected register of both classes through both ports.
    task automatic sweep_reads(input string req);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < ARCH; i++)
                step(req, 1'b0, c[0], i, c[0], ARCH - 1 - i, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map after reset, both classes, both ports.
        sweep_reads("R1");
        // R9: request without a destination, and a destination without a request.
        step("R9", 1'b1, 1'b0, 3, 1'b1, 3, 1'b0, 1'b0, 5, 1'b0, 1'b0);
        step("R9", 1'b0, 1'b0, 2, 1'b0, 2, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        step("R9", 1'b0, 1'b0, 2, 1'b1, 2, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        // R2: floating-point pool drains in ascending order.
        for (int d = 2; d < 6; d++)
            step("R2", 1'b1, 1'b1, d, 1'b1, 1, 1'b1, 1'b1, d, 1'b0, 1'b0);
        // R7: empty floating-point pool stalls and leaves fp6 untouched.
        step("R7", 1'b1, 1'b1, 6, 1'b1, 6, 1'b1, 1'b1, 6, 1'b0, 1'b0);
        step("R7", 1'b0, 1'b1, 6, 1'b0, 6, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R5: integer space still renames and is independent.
        step("R5", 1'b1, 1'b1, 3, 1'b0, 3, 1'b1, 1'b0, 3, 1'b0, 1'b0);
        step("R5", 1'b0, 1'b1, 3, 1'b0, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R3: full read sweep after renames.
        sweep_reads("R3");

        // R4: read-and-write of the same register sees the old tag.
        step("R4", 1'b1, 1'b0, 4, 1'b0, 4, 1'b1, 1'b0, 4, 1'b0, 1'b0);
        step("R4", 1'b0, 1'b0, 4, 1'b0, 4, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        // Drain the integer pool.
        step("R2", 1'b1, 1'b0, 5, 1'b0, 6, 1'b1, 1'b0, 5, 1'b0, 1'b0);
        step("R2", 1'b1, 1'b0, 6, 1'b0, 5, 1'b1, 1'b0, 6, 1'b0, 1'b0);
        // R6: integer 0 with an empty pool: no stall, no tag.
        step("R6", 1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        step("R6", 1'b0, 1'b0, 0, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R7 and R8: release into empty pool does not clear the same-cycle stall.
        step("R8", 1'b1, 1'b0, 1, 1'b0, 1, 1'b1, 1'b0, 1, 1'b1, 1'b0);
        step("R8", 1'b1, 1'b0, 1, 1'b0, 1, 1'b1, 1'b0, 1, 1'b0, 1'b0);
        // R8: release only, then allocate and release together, then reuse.
        step("R8", 1'b0, 1'b0, 1, 1'b0, 2, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        step("R8", 1'b1, 1'b0, 7, 1'b0, 1, 1'b1, 1'b0, 7, 1'b1, 1'b0);
        step("R8", 1'b1, 1'b0, 7, 1'b0, 2, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        // R8: recycled floating-point tags come back in release order.
        step("R8", 1'b0, 1'b1, 2, 1'b1, 3, 1'b0, 1'b0, 0, 1'b1, 1'b1);
        step("R8", 1'b0, 1'b1, 4, 1'b1, 5, 1'b0, 1'b0, 0, 1'b1, 1'b1);
        step("R8", 1'b1, 1'b1, 0, 1'b1, 1, 1'b1, 1'b1, 0, 1'b0, 1'b0);
        step("R8", 1'b1, 1'b1, 0, 1'b1, 1, 1'b1, 1'b1, 1, 1'b0, 1'b0);
        // R9: no request leaves integer 2 as it was.
        step("R9", 1'b0, 1'b0, 2, 1'b1, 0, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        step("R9", 1'b0, 1'b0, 2, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        sweep_reads("R3");

        // R3, R5, R7, R8: long mixed pattern with recycling.
        for (int i = 0; i < 600; i++) begin
            step("R3", 1'b1, i[1], (i * 3) % ARCH, i[2], (i * 5 + 1) % ARCH,
                 (i % 4) != 3, i[0] ^ i[3], (i * 7 + 2) % ARCH,
                 (i % 3) != 2, i[1] ^ i[0]);
        end
        sweep_reads("R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule